// File: doc/BRIEF.md
# Banked Address Translator

This block widens the 16-bit addresses of an 8-bit processor into 20-bit physical addresses. The processor's space is split into two 32 KB windows. The lower window (address bit 15 clear) always lands in physical bank 0. The upper window (bit 15 set) lands in whichever 32 KB bank the bank register currently holds. Software selects a bank by writing the register at processor address 0x1F0F. It can read the current bank back from the same address.

The address path is purely combinational. A register write takes effect on the clock edge that ends the write cycle, so the very next access to the upper window already uses the new bank. While the vector-fetch input is high, an upper-window access is steered to bank 1 whatever the register holds, and the register is not touched. Reset loads bank 1, so the first fetches after reset come from bank 1.

The processor side has no valid/ready pairing. Every access completes in the cycle it is presented, and the block never applies back-pressure. All pins are plain control, address and data lines.

Top module: `bank_xlat_top`

## Requirements
- R1: When cpu_addr[15] is 0, phys_addr[19:15] is 0 and phys_addr[14:0] equals cpu_addr[14:0], in the same cycle and whatever vec_fetch is.
- R2: When cpu_addr[15] is 1 and vec_fetch is 0, phys_addr[19:15] equals the bank register and phys_addr[14:0] equals cpu_addr[14:0], in the same cycle.
- R3: When cpu_addr[15] is 1 and vec_fetch is 1, phys_addr[19:15] equals 1. A vector fetch never changes the bank register.
- R4: After reset the bank register holds 1.
- R5: A clock edge with cpu_we high and cpu_addr equal to 0x1F0F loads cpu_wdata[4:0] into the bank register. The next cycle's upper-window access uses the new bank.
- R6: When cpu_re is high and cpu_addr is 0x1F0F, rd_valid is 1 and rd_data holds the bank register in bits 4..0, in the same cycle. Otherwise rd_valid is 0 and rd_data is 0.
- R7: Bits 7..5 of the register ignore writes and always read back as 0.
- R8: bank_zero is 1 exactly when the bank register holds 0. The value 0 is still accepted and mapped.
- R9: A write to any address other than 0x1F0F leaves the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| vec_fetch | input | 1 | High while an interrupt vector is fetched |
| phys_addr | output | 20 | Translated physical address |
| rd_data | output | 8 | Register read data, 0 when not selected |
| rd_valid | output | 1 | High when rd_data carries the bank register |
| bank_zero | output | 1 | High while bank 0 is selected for the upper window |

## Verification
The bench goes after four mistakes. A design that applied the bank to the lower window would put nonzero upper bits on addresses below 0x8000. A design that let vector fetch write the register would read back 1 after the fetch instead of the programmed value. A design that delayed the bank update by a cycle would translate the access right after a write with the old bank. A design that kept bits 7..5 or decoded the address loosely would show high bits in the read-back, or would change banks on writes to nearby addresses. The bench also writes bank 0 and checks that the zero flag rises while the mapping still follows the register.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  localparam int unsigned CPU_AW_D   = 16;
  localparam int unsigned PHYS_AW_D  = 20;
  localparam int unsigned DW_D       = 8;
  localparam logic [15:0] REG_ADDR_D = 16'h1F0F;
  localparam int unsigned RST_BANK_D = 1;
  localparam int unsigned VEC_BANK_D = 1;

  // width of the bank field given both address widths
  function automatic int unsigned bank_width(input int unsigned cpu_aw,
                                             input int unsigned phys_aw);
    return phys_aw - cpu_aw + 1;
  endfunction
endpackage

// File: rtl/bank_reg.sv
module bank_reg #(
  parameter int unsigned DW     = 8,
  parameter int unsigned BANK_W = 5,
  parameter int unsigned RST_V  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [BANK_W-1:0] bank_q
);
  // only the low bank field is stored; higher data bits are dropped
  logic [BANK_W-1:0] nxt;
  assign nxt = wr_data[BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= BANK_W'(RST_V);
    else if (wr_en) bank_q <= nxt;
  end
endmodule

// File: rtl/addr_map.sv
module addr_map #(
  parameter int unsigned CPU_AW  = 16,
  parameter int unsigned BANK_W  = 5,
  parameter int unsigned VEC_BNK = 1
) (
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic                     vec_fetch,
  input  logic [BANK_W-1:0]        bank_q,
  output logic [CPU_AW+BANK_W-2:0] phys_addr
);
  localparam int unsigned WIN_W = CPU_AW - 1;

  logic              upper;
  logic [BANK_W-1:0] sel_bank;

  assign upper = cpu_addr[CPU_AW-1];

  always_comb begin
    if (!upper)         sel_bank = '0;
    else if (vec_fetch) sel_bank = BANK_W'(VEC_BNK);
    else                sel_bank = bank_q;
  end

  assign phys_addr = {sel_bank, cpu_addr[WIN_W-1:0]};
endmodule

// File: rtl/reg_port.sv
module reg_port #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned BANK_W   = 5,
  parameter logic [15:0] REG_ADDR = 16'h1F0F
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [BANK_W-1:0] bank_q,
  output logic              wr_hit,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  logic sel;
  logic [DW-1:0] rd_word;

  assign sel    = (cpu_addr == CPU_AW'(REG_ADDR));
  assign wr_hit = sel & cpu_we;

  // zero-extend the bank field to the bus width
  generate
    if (DW > BANK_W) begin : g_pad
      assign rd_word = {{(DW-BANK_W){1'b0}}, bank_q};
    end else begin : g_full
      assign rd_word = bank_q[DW-1:0];
    end
  endgenerate

  assign rd_valid = sel & cpu_re;
  assign rd_data  = rd_valid ? rd_word : '0;
endmodule

// File: rtl/bank_xlat_top.sv
module bank_xlat_top
  import bank_xlat_pkg::*;
#(
  parameter int unsigned CPU_AW   = CPU_AW_D,
  parameter int unsigned PHYS_AW  = PHYS_AW_D,
  parameter int unsigned DW       = DW_D,
  parameter logic [15:0] REG_ADDR = REG_ADDR_D,
  parameter int unsigned RST_BANK = RST_BANK_D,
  parameter int unsigned VEC_BANK = VEC_BANK_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic               cpu_we,
  input  logic               cpu_re,
  input  logic               vec_fetch,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  output logic               bank_zero
);
  localparam int unsigned BANK_W = bank_width(CPU_AW, PHYS_AW);

  logic              wr_hit;
  logic [BANK_W-1:0] bank_q;

  reg_port #(.CPU_AW(CPU_AW), .DW(DW), .BANK_W(BANK_W), .REG_ADDR(REG_ADDR)) u_port (
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re), .bank_q(bank_q),
    .wr_hit(wr_hit), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  bank_reg #(.DW(DW), .BANK_W(BANK_W), .RST_V(RST_BANK)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wr_data(cpu_wdata), .bank_q(bank_q)
  );

  addr_map #(.CPU_AW(CPU_AW), .BANK_W(BANK_W), .VEC_BNK(VEC_BANK)) u_map (
    .cpu_addr(cpu_addr), .vec_fetch(vec_fetch), .bank_q(bank_q), .phys_addr(phys_addr)
  );

  assign bank_zero = (bank_q == '0);
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned PHYS_AW  = 20,
  parameter int unsigned DW       = 8,
  parameter logic [15:0] REG_ADDR = 16'h1F0F,
  parameter int unsigned VEC_BANK = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic [DW-1:0]      cpu_wdata,
  input logic               cpu_we,
  input logic               vec_fetch,
  input logic [PHYS_AW-1:0] phys_addr,
  input logic [DW-1:0]      rd_data,
  input logic               rd_valid,
  input logic               bank_zero
);
  localparam int unsigned BANK_W = PHYS_AW - CPU_AW + 1;
  localparam int unsigned WIN_W  = CPU_AW - 1;

  // R1
  lower_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[CPU_AW-1] |-> (phys_addr[PHYS_AW-1:WIN_W] == '0));

  // R3
  vec_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_AW-1] && vec_fetch) |-> (phys_addr[PHYS_AW-1:WIN_W] == BANK_W'(VEC_BANK)));

  // R5
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == CPU_AW'(REG_ADDR) && rst_n)
      |=> ((cpu_addr[CPU_AW-1] && !vec_fetch) |-> (phys_addr[PHYS_AW-1:WIN_W] == $past(cpu_wdata[BANK_W-1:0]))));

  // R7
  rd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DW-1:BANK_W] == '0));

  // R6
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data == '0) |-> bank_zero);
endmodule

bind bank_xlat_top bank_xlat_chk #(
  .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW), .DW(DW), .REG_ADDR(REG_ADDR), .VEC_BANK(VEC_BANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .vec_fetch(vec_fetch), .phys_addr(phys_addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .bank_zero(bank_zero)
);

// File: tb/sim_bank_xlat_top.sv
`timescale 1ns/1ps
module sim_bank_xlat_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0, vec_fetch = 1'b0;
  logic [19:0] phys_addr;
  logic [7:0]  rd_data;
  logic        rd_valid, bank_zero;

  int errors = 0;
  int checks = 0;
  logic [4:0] mdl_bank;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_xlat_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .vec_fetch(vec_fetch),
    .phys_addr(phys_addr), .rd_data(rd_data), .rd_valid(rd_valid), .bank_zero(bank_zero)
  );

  function automatic logic [19:0] exp_phys(input logic [15:0] a, input logic v, input logic [4:0] b);
    if (!a[15]) return {5'd0, a[14:0]};
    if (v)      return {5'd1, a[14:0]};
    return {b, a[14:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, let combinational outputs settle
  task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic we, input logic re, input logic v);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = we; cpu_re = re; vec_fetch = v;
    #1;
  endtask

  task automatic check_all(input string req);
    chk({req, " phys"}, 32'(phys_addr), 32'(exp_phys(cpu_addr, vec_fetch, mdl_bank)));
    if (cpu_re && cpu_addr == 16'h1F0F) begin
      chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
      chk({req, " rd_data"}, 32'(rd_data), {27'd0, mdl_bank});
    end else begin
      chk({req, " rd_idle"}, {31'd0, rd_valid}, 32'd0);
      chk({req, " rd_zero"}, 32'(rd_data), 32'd0);
    end
    chk({req, " R8 zero flag"}, 32'(bank_zero), 32'(mdl_bank == 5'd0));
  endtask

  // commit a cycle: the model follows R5/R9
  task automatic tick;
    @(posedge clk);
    if (cpu_we && cpu_addr == 16'h1F0F) mdl_bank = cpu_wdata[4:0];
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog actual=timeout expected=done");
    errors++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    mdl_bank = 5'd1;
    repeat (3) @(posedge clk);
    // R4: reset value visible through read-back during and after reset
    drive(16'h1F0F, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R4 reset rd", 32'(rd_data), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    drive(16'h9234, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R4 R2 reset map", 32'(phys_addr), 32'h0_9234 | 32'h0_8000);
    // R7: high bits ignored
    drive(16'h1F0F, 8'hF6, 1'b1, 1'b0, 1'b0); tick;
    drive(16'h1F0F, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R7 rd high bits", 32'(rd_data), 32'h16);
    // R5: write from lower window, next access upper uses new bank
    drive(16'h1F0F, 8'h0B, 1'b1, 1'b0, 1'b0); tick;
    drive(16'hC001, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5 next access", 32'(phys_addr), 32'h5C001 | 32'h0);
    // R3: vector fetch to bank 1, register untouched
    drive(16'hFFFE, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R3 vec map", 32'(phys_addr), 32'h0FFFE);
    tick;
    drive(16'h1F0F, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R3 reg unchanged", 32'(rd_data), 32'h0B);
    // R1: lower window with vec_fetch
    drive(16'h7FFF, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R1 lower vec", 32'(phys_addr), 32'h07FFF);
    // R9: near-miss addresses
    drive(16'h1F0E, 8'h03, 1'b1, 1'b0, 1'b0); tick;
    drive(16'h9F0F, 8'h03, 1'b1, 1'b0, 1'b0); tick;
    drive(16'h1F0F, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R9 no write", 32'(rd_data), 32'h0B);
    // R8: bank 0 accepted, flag set, mapping follows
    drive(16'h1F0F, 8'h00, 1'b1, 1'b0, 1'b0); tick;
    drive(16'h8123, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R8 flag", 32'(bank_zero), 32'd1);
    chk("R8 R2 map bank0", 32'(phys_addr), 32'h00123);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'h1F0F : 16'($urandom);
      drive(a, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5 == 0));
      check_all(a[15] ? (vec_fetch ? "R3" : "R2") : "R1 R6");
      tick;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule